// File: doc/BRIEF.md
# DRAM Node Range Decoder

This block takes a physical system address and finds which node's DRAM window owns it. A set of address windows comes in as static configuration. Each window carries a base, an inclusive limit, an enable field, a destination node, and a pair of node-interleave fields. The first enabled window that contains the address wins, provided its interleave select matches the address bits that interleaving consumes. The block reports the hit, the winning node, the interleave bit count and the window base.

Two checks run beside the range search. If the hit lands inside the MMIO hole that sits under 4 GB, the result is marked out of bounds. If swapping of the low interleaved region is on, the address that the block passes downstream has its region field XORed with the region base.

Each request presents one address with a valid strobe. Exactly one registered response comes back on the following cycle.

Top module: `dram_range_dec`

## Requirements
- R1: Window i spans from {base_hi[7:0], base_lo[31:16], 24'h000000} up to {limit_hi[7:0], limit_lo[31:16], 24'hFFFFFF}, and both ends are inclusive. Each window uses 32-bit lo words and 8-bit hi words packed at index i.
- R2: A window takes part only when base_lo[1:0] is nonzero. A disabled window never produces a hit, even if it contains the address.
- R3: Let ilen = base_lo[10:8] and isel = limit_lo[10:8]. When ilen is nonzero, a window matches only if isel equals addr[14:12] & ilen.
- R4: When several windows match, the lowest index wins.
- R5: On a hit, rsp_node_o is limit_lo[2:0] of the winner and rsp_base_o is the winner's base. On a miss, hit, node, base, ilog, oob and cfg_err are all zero.
- R6: On a hit, ilen values 0, 1, 3 and 7 give rsp_ilog_o values 0, 1, 2 and 3. Any other ilen gives rsp_cfg_err_o = 1 with rsp_ilog_o = 0.
- R7: rsp_oob_o is 1 when there is a hit, hole_valid_i is set, and {hole_base_i, 24'h0} <= addr < 2^32. In every other case it is 0.
- R8: With swap_en_i set, addr[47:34] zero, and the field f = addr[33:27] either in [rgn_base_i, rgn_limit_i] or below rgn_size_i, rsp_addr_o is addr with bits [33:27] XORed with rgn_base_i. Otherwise rsp_addr_o equals addr. Hit, hole and range tests always use the unswapped address.
- R9: Each cycle with req_valid_i high produces exactly one response with rsp_valid_o high on the next cycle. A cycle with req_valid_i low produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request strobe |
| req_addr_i | input | 48 | system address |
| base_lo_i | input | 32*NUM_RANGES | window base words: base[39:24] in bits 31:16, ilen in bits 10:8, enable in bits 1:0 |
| base_hi_i | input | 8*NUM_RANGES | window base bits 47:40 |
| limit_lo_i | input | 32*NUM_RANGES | window limit words: limit[39:24] in bits 31:16, isel in bits 10:8, node in bits 2:0 |
| limit_hi_i | input | 8*NUM_RANGES | window limit bits 47:40 |
| hole_valid_i | input | 1 | hole enable |
| hole_base_i | input | 8 | hole base, address bits 31:24 |
| swap_en_i | input | 1 | swapped region enable |
| rgn_base_i | input | 7 | swap region base, in 128 MB units |
| rgn_limit_i | input | 7 | swap region limit, in 128 MB units |
| rgn_size_i | input | 7 | swap region size, in 128 MB units |
| rsp_valid_o | output | 1 | response strobe |
| rsp_hit_o | output | 1 | a window matched |
| rsp_node_o | output | 3 | destination node |
| rsp_ilog_o | output | 2 | number of node-interleave bits |
| rsp_base_o | output | 48 | base of the winning window |
| rsp_oob_o | output | 1 | hit falls inside the hole |
| rsp_cfg_err_o | output | 1 | winner has an illegal ilen |
| rsp_addr_o | output | 48 | address after the swap remap |

## Verification
Every response field comes from a single output register. All fields are therefore due in the cycle after the request edge, at the same time, with no field trailing the others.

The driver sets up a request just after a falling edge and queues the expected result. The monitor then looks at the outputs on the next falling edge, half a cycle after the register loads. It takes one queued entry for each asserted rsp_valid_o.

A response with an empty queue counts as a failure. So does any entry left over once the stimulus ends. Idle cycles mixed in between requests show that no response appears without a request.

// File: rtl/dram_dec_pkg.sv
`timescale 1ns/1ps
package dram_dec_pkg;
  localparam int ADDR_W   = 48;
  localparam int SEG_LSB  = 24;
  localparam int NODE_W   = 3;
  localparam int ILEN_W   = 3;
  localparam int ILOG_W   = 2;
  localparam int SW_LSB   = 27;
  localparam int SW_W     = 7;
  localparam int SW_MSB   = SW_LSB + SW_W - 1;
  localparam int HOLE_W   = 8;
  localparam int LO_W     = 32;
  localparam int HI_W     = 8;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    logic [ILEN_W-1:0] ilen;
    logic [ADDR_W-1:0] base;
  } win_fld_t;

  typedef struct packed {
    logic [ILOG_W-1:0] ilog;
    logic              err;
  } ilog_res_t;

  function automatic ilog_res_t ilog_decode(input logic [ILEN_W-1:0] ilen);
    ilog_res_t r;
    r = '0;
    unique case (ilen)
      3'd0: r.ilog = 2'd0;
      3'd1: r.ilog = 2'd1;
      3'd3: r.ilog = 2'd2;
      3'd7: r.ilog = 2'd3;
      default: r.err = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dram_range_cmp.sv
`timescale 1ns/1ps
module dram_range_cmp
  import dram_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LO_W-1:0]   base_lo_i,
  input  logic [HI_W-1:0]   base_hi_i,
  input  logic [LO_W-1:0]   limit_lo_i,
  input  logic [HI_W-1:0]   limit_hi_i,
  output logic              match_o,
  output win_fld_t          fld_o
);
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic [ILEN_W-1:0] ilen, isel;
  logic              en, in_span, il_ok;

  assign lo_addr = {base_hi_i, base_lo_i[31:16], {SEG_LSB{1'b0}}};
  assign hi_addr = {limit_hi_i, limit_lo_i[31:16], {SEG_LSB{1'b1}}};
  assign en      = |base_lo_i[1:0];
  assign ilen    = base_lo_i[10:8];
  assign isel    = limit_lo_i[10:8];
  assign in_span = (addr_i >= lo_addr) && (addr_i <= hi_addr);
  // node interleave: select must equal the address bits the enable mask keeps
  assign il_ok   = (ilen == '0) || (isel == (addr_i[14:12] & ilen));
  assign match_o = en && in_span && il_ok;

  assign fld_o.node = limit_lo_i[NODE_W-1:0];
  assign fld_o.ilen = ilen;
  assign fld_o.base = lo_addr;
endmodule

// File: rtl/dram_prio_sel.sv
`timescale 1ns/1ps
module dram_prio_sel #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_swap_remap.sv
`timescale 1ns/1ps
module dram_swap_remap
  import dram_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [SW_W-1:0]   rgn_base_i,
  input  logic [SW_W-1:0]   rgn_limit_i,
  input  logic [SW_W-1:0]   rgn_size_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SW_W-1:0] fld;
  logic            low_ok, in_rgn, in_size, swap;

  assign fld     = addr_i[SW_MSB:SW_LSB];
  assign low_ok  = (addr_i[ADDR_W-1:SW_MSB+1] == '0);
  assign in_rgn  = (fld >= rgn_base_i) && (fld <= rgn_limit_i);
  assign in_size = (fld < rgn_size_i);
  assign swap    = en_i && low_ok && (in_rgn || in_size);

  always_comb begin
    addr_o = addr_i;
    if (swap) addr_o[SW_MSB:SW_LSB] = fld ^ rgn_base_i;
  end
endmodule

// File: rtl/dram_range_dec.sv
`timescale 1ns/1ps
module dram_range_dec
  import dram_dec_pkg::*;
#(
  parameter int NUM_RANGES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [NUM_RANGES*LO_W-1:0] base_lo_i,
  input  logic [NUM_RANGES*HI_W-1:0] base_hi_i,
  input  logic [NUM_RANGES*LO_W-1:0] limit_lo_i,
  input  logic [NUM_RANGES*HI_W-1:0] limit_hi_i,
  input  logic                       hole_valid_i,
  input  logic [HOLE_W-1:0]          hole_base_i,
  input  logic                       swap_en_i,
  input  logic [SW_W-1:0]            rgn_base_i,
  input  logic [SW_W-1:0]            rgn_limit_i,
  input  logic [SW_W-1:0]            rgn_size_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_hit_o,
  output logic [NODE_W-1:0]          rsp_node_o,
  output logic [ILOG_W-1:0]          rsp_ilog_o,
  output logic [ADDR_W-1:0]          rsp_base_o,
  output logic                       rsp_oob_o,
  output logic                       rsp_cfg_err_o,
  output logic [ADDR_W-1:0]          rsp_addr_o
);
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

  logic [NUM_RANGES-1:0] match, grant;
  logic                  any_hit;
  logic [IDX_W-1:0]      win_idx;
  win_fld_t              fld [NUM_RANGES];
  win_fld_t              win;
  ilog_res_t             il;
  logic                  in_hole;
  logic [ADDR_W-1:0]     swp_addr;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    dram_range_cmp u_cmp (
      .addr_i     (req_addr_i),
      .base_lo_i  (base_lo_i[g*LO_W +: LO_W]),
      .base_hi_i  (base_hi_i[g*HI_W +: HI_W]),
      .limit_lo_i (limit_lo_i[g*LO_W +: LO_W]),
      .limit_hi_i (limit_hi_i[g*HI_W +: HI_W]),
      .match_o    (match[g]),
      .fld_o      (fld[g])
    );
  end

  dram_prio_sel #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_prio (
    .req_i   (match),
    .grant_o (grant),
    .any_o   (any_hit),
    .idx_o   (win_idx)
  );

  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (grant[i]) win = fld[i];
  end

  assign il = ilog_decode(win.ilen);

  // hole sits below 4 GB: upper 16 address bits must be zero
  assign in_hole = hole_valid_i && (req_addr_i[ADDR_W-1:32] == '0) &&
                   (req_addr_i[31:SEG_LSB] >= hole_base_i);

  dram_swap_remap u_swap (
    .addr_i      (req_addr_i),
    .en_i        (swap_en_i),
    .rgn_base_i  (rgn_base_i),
    .rgn_limit_i (rgn_limit_i),
    .rgn_size_i  (rgn_size_i),
    .addr_o      (swp_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_hit_o     <= 1'b0;
      rsp_node_o    <= '0;
      rsp_ilog_o    <= '0;
      rsp_base_o    <= '0;
      rsp_oob_o     <= 1'b0;
      rsp_cfg_err_o <= 1'b0;
      rsp_addr_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o     <= any_hit;
        rsp_node_o    <= any_hit ? win.node : '0;
        rsp_ilog_o    <= (any_hit && !il.err) ? il.ilog : '0;
        rsp_base_o    <= any_hit ? win.base : '0;
        rsp_oob_o     <= any_hit && in_hole;
        rsp_cfg_err_o <= any_hit && il.err;
        rsp_addr_o    <= swp_addr;
      end
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R4
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~match) == '0));
  // R7
  oob_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_oob_o |-> rsp_hit_o);
  // R6
  cfg_err_ilog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cfg_err_o |-> rsp_hit_o && (rsp_ilog_o == '0));
  // R5
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> (rsp_node_o == '0) && (rsp_base_o == '0) && !rsp_cfg_err_o);
  // R8
  swap_field_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_addr_o[ADDR_W-1:SW_MSB+1] == $past(req_addr_i[ADDR_W-1:SW_MSB+1])) &&
                    (rsp_addr_o[SW_LSB-1:0] == $past(req_addr_i[SW_LSB-1:0])));
endmodule

// File: tb/dram_range_dec_tb_top.sv
`timescale 1ns/1ps
module dram_range_dec_tb_top;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            req_valid = 1'b0;
  logic [47:0]     req_addr  = '0;
  logic [NR*32-1:0] base_lo, limit_lo;
  logic [NR*8-1:0]  base_hi, limit_hi;
  logic            hole_v = 1'b0;
  logic [7:0]      hole_b = '0;
  logic            sw_en = 1'b0;
  logic [6:0]      rb = '0, rl = '0, rs = '0;

  logic            rsp_valid, rsp_hit, rsp_oob, rsp_err;
  logic [2:0]      rsp_node;
  logic [1:0]      rsp_ilog;
  logic [47:0]     rsp_base, rsp_addr;

  // bench-side window description
  logic [1:0]  w_en   [NR];
  logic [23:0] w_lo   [NR];
  logic [23:0] w_hi   [NR];
  logic [2:0]  w_ilen [NR];
  logic [2:0]  w_isel [NR];
  logic [2:0]  w_node [NR];

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      base_lo[i*32 +: 32]  = {w_lo[i][15:0], 5'd0, w_ilen[i], 6'd0, w_en[i]};
      base_hi[i*8 +: 8]    = w_lo[i][23:16];
      limit_lo[i*32 +: 32] = {w_hi[i][15:0], 5'd0, w_isel[i], 5'd0, w_node[i]};
      limit_hi[i*8 +: 8]   = w_hi[i][23:16];
    end
  end

  dram_range_dec #(.NUM_RANGES(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .base_lo_i(base_lo), .base_hi_i(base_hi), .limit_lo_i(limit_lo), .limit_hi_i(limit_hi),
    .hole_valid_i(hole_v), .hole_base_i(hole_b), .swap_en_i(sw_en),
    .rgn_base_i(rb), .rgn_limit_i(rl), .rgn_size_i(rs),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_node_o(rsp_node),
    .rsp_ilog_o(rsp_ilog), .rsp_base_o(rsp_base), .rsp_oob_o(rsp_oob),
    .rsp_cfg_err_o(rsp_err), .rsp_addr_o(rsp_addr)
  );

  typedef struct {
    logic        hit, oob, err;
    logic [2:0]  node;
    logic [1:0]  ilog;
    logic [47:0] base, addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;

  function automatic exp_t model(input logic [47:0] a, input string tag);
    exp_t e;
    logic [6:0] f;
    logic [2:0] il;
    e.hit = 0; e.oob = 0; e.err = 0; e.node = 0; e.ilog = 0; e.base = 0;
    e.tag = tag; il = 0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (w_en[i] != 0 && a >= {w_lo[i], 24'h0} && a <= {w_hi[i], 24'hFFFFFF} &&
          (w_ilen[i] == 0 || w_isel[i] == (a[14:12] & w_ilen[i]))) begin
        e.hit = 1; e.node = w_node[i]; e.base = {w_lo[i], 24'h0}; il = w_ilen[i];
      end
    end
    if (e.hit) begin
      case (il)
        3'd0: e.ilog = 0;
        3'd1: e.ilog = 1;
        3'd3: e.ilog = 2;
        3'd7: e.ilog = 3;
        default: e.err = 1;
      endcase
      e.oob = hole_v && a >= {16'h0, hole_b, 24'h0} && a < 48'h1_0000_0000;
    end
    f = a[33:27];
    e.addr = a;
    if (sw_en && a[47:34] == 0 && ((f >= rb && f <= rl) || f < rs))
      e.addr[33:27] = f ^ rb;
    return e;
  endfunction

  task automatic send(input logic [47:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    q.push_back(model(a, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic clear_win();
    for (int i = 0; i < NR; i++) begin
      w_en[i] = 0; w_lo[i] = 0; w_hi[i] = 0; w_ilen[i] = 0; w_isel[i] = 0; w_node[i] = 0;
    end
  endtask

  task automatic set_win(input int i, input logic [1:0] en, input logic [23:0] lo,
                         input logic [23:0] hi, input logic [2:0] ilen,
                         input logic [2:0] isel, input logic [2:0] node);
    w_en[i] = en; w_lo[i] = lo; w_hi[i] = hi; w_ilen[i] = ilen; w_isel[i] = isel; w_node[i] = node;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9: response with no request (actual valid=1, expected 0)");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_node !== e.node || rsp_ilog !== e.ilog ||
            rsp_base !== e.base || rsp_oob !== e.oob || rsp_err !== e.err ||
            rsp_addr !== e.addr) begin
          errors++;
          $display("FAIL %s: actual hit=%0b node=%0d ilog=%0d base=%h oob=%0b err=%0b addr=%h expected hit=%0b node=%0d ilog=%0d base=%h oob=%0b err=%0b addr=%h",
                   e.tag, rsp_hit, rsp_node, rsp_ilog, rsp_base, rsp_oob, rsp_err, rsp_addr,
                   e.hit, e.node, e.ilog, e.base, e.oob, e.err, e.addr);
        end
      end
    end
  end

  task automatic drain_check();
    idle(3);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d responses missing (actual pending %0d, expected 0)", q.size(), q.size());
      q.delete();
    end
  endtask

  bit done = 0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_win();
    repeat (3) @(negedge clk);
    // reset state
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_addr !== 0) begin
      errors++;
      $display("FAIL R9 reset: actual valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R4 R5: plain windows, disabled window, overlap
    set_win(0, 2'd0, 24'h000, 24'h0FF, 0, 0, 3'd7);   // disabled, covers 0..4G
    set_win(1, 2'd1, 24'h000, 24'h03F, 0, 0, 3'd1);   // 0..1G-1
    set_win(2, 2'd3, 24'h020, 24'h0FF, 0, 0, 3'd2);   // 512M..4G-1
    set_win(3, 2'd2, 24'h100, 24'h1FF, 0, 0, 3'd3);   // 4G..8G-1
    idle(1);
    send(48'h0, "R2");
    send(48'h0_3FFF_FFFF, "R1");
    send(48'h0_4000_0000, "R1");
    send(48'h0_2000_0000, "R4");
    idle(2);
    send(48'h0_FFFF_FFFF, "R5");
    send(48'h1_0000_0000, "R1");
    send(48'h1_FFFF_FFFF, "R1");
    send(48'h2_0000_0000, "R5");
    send(48'hFFFF_FFFF_FFFF, "R5");
    for (int k = 0; k < 40; k++) begin
      send({14'h0, 2'($urandom), 32'($urandom)}, "R4");
      if (k % 7 == 3) idle(1);
    end
    drain_check();

    // R3 R6: node interleave
    clear_win();
    for (int i = 0; i < 4; i++) set_win(i, 2'd1, 24'h000, 24'h0FF, 3'd3, 3'(i), 3'(4 + i));
    set_win(4, 2'd1, 24'h100, 24'h1FF, 3'd5, 3'd1, 3'd1);
    set_win(5, 2'd1, 24'h200, 24'h2FF, 3'd1, 3'd1, 3'd2);
    set_win(6, 2'd1, 24'h300, 24'h3FF, 3'd7, 3'd6, 3'd6);
    idle(1);
    for (int s = 0; s < 8; s++) begin
      send(48'h0_0000_0000 | (48'(s) << 12), "R3");
      send(48'h1_0000_0000 | (48'(s) << 12), "R6");
      send(48'h2_0000_0000 | (48'(s) << 12), "R3");
      send(48'h3_0000_0000 | (48'(s) << 12), "R6");
    end
    drain_check();

    // R7: hole below 4 GB
    clear_win();
    set_win(0, 2'd1, 24'h000, 24'h1FF, 0, 0, 3'd5);
    hole_v = 1'b1; hole_b = 8'hC0;
    idle(1);
    send(48'h0_BFFF_FFFF, "R7");
    send(48'h0_C000_0000, "R7");
    send(48'h0_FFFF_FFFF, "R7");
    send(48'h1_0000_0000, "R7");
    send(48'h2_C000_0000, "R7");  // miss, no oob
    idle(2);
    hole_v = 1'b0;
    idle(1);
    send(48'h0_C000_0000, "R7");
    drain_check();

    // R8: swapped region
    clear_win();
    set_win(0, 2'd1, 24'h000, 24'h3FF, 0, 0, 3'd0);
    sw_en = 1'b1; rb = 7'd2; rl = 7'd3; rs = 7'd2;
    idle(1);
    for (int f = 0; f < 6; f++) send((48'(f) << 27) | 48'h123_4567, "R8");
    send(48'h4_1000_0000, "R8");      // bit 34 set: no swap
    send(48'h3_F800_0000, "R8");      // field 127
    idle(2);
    sw_en = 1'b0;
    idle(1);
    send(48'h0_1000_0000, "R8");
    drain_check();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule